// File: doc/BRIEF.md
# Hard-Decision Add-Compare-Select Unit for a 4-State Rate-1/2 Code

This block is the metric engine of a hard-decision Viterbi decoder for the memory-2, rate-1/2 convolutional code with generator polynomials 7 and 5 (octal). Each time a received 2-bit symbol arrives with its valid strobe, the unit forms the Hamming-distance branch metrics. Two add-compare-select butterflies then work in parallel and update the four state metrics. Alongside the new metrics, the unit reports one survivor decision bit per state and the index of the state that currently has the smallest metric.

The metrics are 5-bit registers that are allowed to wrap. Every comparison takes the sign of a 5-bit two's-complement difference, so the survivor choice is unaffected when a metric overflows, and no renormalisation step is needed. A downstream traceback memory stores the decision bits and uses the best-state index as its starting row. A synchronous reset and a frame-clear strobe both return every metric to zero.

Top module: `acs4_hd`

## Requirements
- R1: After a synchronous reset, or in the cycle after `clr_i` is high, all four metrics, `dec_o`, `best_o` and `out_valid_o` are zero. `clr_i` takes priority over `in_valid_i`.
- R2: The branch metric is the number of bit positions in which `sym_i` differs from the branch label, so it is 0, 1 or 2. `sym_i[1]` is compared with the generator-7 output and `sym_i[0]` with the generator-5 output.
- R3: State k holds the newest input in bit 0 and the older input in bit 1. Input u moves state k to state {k[0],u}. The generator-7 output of that transition is u^k[0]^k[1], and the generator-5 output is u^k[1]. State s therefore has an upper predecessor s>>1 and a lower predecessor (s>>1)+2.
- R4: Each new metric is the smaller of the two candidates, where a candidate is a predecessor metric plus its branch metric. Decision bit s (`dec_o[s]`) is 1 only when the lower predecessor is strictly smaller. A tie gives 0.
- R5: Metrics are stored modulo 32 and compared by the sign bit of their 5-bit difference. Over long streams in which the metrics wrap many times, the results stay equal to those of unbounded integer metrics taken modulo 32.
- R6: `best_o` is the state with the smallest metric under the modular comparison, and ties go to the lowest index. From one accepted symbol to the next, the best metric grows by 0, 1 or 2.
- R7: Outputs change at the clock edge that samples `in_valid_i` high, and `out_valid_o` is high for exactly the cycle after each accepted symbol. When neither `in_valid_i` nor `clr_i` is high, the metrics, decisions and best index hold their values.
- R8: Each metric exceeds the best metric by at most 4 (modulo 32).
- R9: Starting from cleared metrics, the received pairs 10,01,01,00,10,11 leave state 0 with metric 1 and `best_o` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Start-of-frame clear of all metrics |
| in_valid_i | input | 1 | Received symbol strobe |
| sym_i | input | 2 | Hard-decision symbol, bit 1 = generator-7 bit, bit 0 = generator-5 bit |
| metric_o | output | 20 | State metrics, state s at bits [5s+4:5s] |
| dec_o | output | 4 | Survivor decision per state, 1 = lower predecessor |
| best_o | output | 2 | Index of the smallest-metric state |
| out_valid_o | output | 1 | High for one cycle after each accepted symbol |

## Verification
Every result of this unit is registered once, so the metrics, decisions, best index and `out_valid_o` for a symbol are due at the rising edge that samples the strobe. A clear is likewise visible after that single edge. The bench drives each symbol on a falling edge and waits for the next rising edge. It samples on the falling edge after that, half a cycle after the outputs settle, and compares them against an unbounded-integer trellis model that is advanced at the same moment. During idle stretches, the bench samples on several consecutive falling edges to confirm that the state holds.

// File: rtl/acs4_pkg.sv
package acs4_pkg;
    localparam int MEM  = 2;
    localparam int NST  = 1 << MEM;
    localparam int NBF  = NST / 2;
    localparam int SW   = MEM;
    localparam int BMW  = 2;
    localparam int NLAB = 4;

    typedef logic [1:0]     sym_t;
    typedef logic [BMW-1:0] bm_t;
endpackage

// File: rtl/acs4_bmu.sv
module acs4_bmu
    import acs4_pkg::*;
(
    input  sym_t                     sym_i,
    output logic [NLAB-1:0][BMW-1:0] bm_o
);
    for (genvar l = 0; l < NLAB; l++) begin : g_lab
        localparam logic [1:0] LAB = 2'(l);
        always_comb begin
            bm_o[l] = BMW'(sym_i[1] ^ LAB[1]) + BMW'(sym_i[0] ^ LAB[0]);
        end
    end
endmodule

// File: rtl/acs4_bfly.sv
module acs4_bfly
    import acs4_pkg::*;
#(
    parameter int MW = 5,
    parameter int J  = 0
) (
    input  logic [MW-1:0]            pm_up_i,
    input  logic [MW-1:0]            pm_lo_i,
    input  logic [NLAB-1:0][BMW-1:0] bm_i,
    output logic [MW-1:0]            pm_even_o,
    output logic [MW-1:0]            pm_odd_o,
    output logic                     dec_even_o,
    output logic                     dec_odd_o
);
    localparam logic [1:0] LA = {1'(J), 1'b0};
    localparam logic [1:0] LB = ~LA;

    logic [MW-1:0] ce_up, ce_lo, co_up, co_lo, de, dodd;

    always_comb begin
        ce_up = pm_up_i + MW'(bm_i[LA]);
        ce_lo = pm_lo_i + MW'(bm_i[LB]);
        co_up = pm_up_i + MW'(bm_i[LB]);
        co_lo = pm_lo_i + MW'(bm_i[LA]);
        de    = ce_lo - ce_up;
        dodd  = co_lo - co_up;
        dec_even_o = de[MW-1];
        dec_odd_o  = dodd[MW-1];
        pm_even_o  = dec_even_o ? ce_lo : ce_up;
        pm_odd_o   = dec_odd_o  ? co_lo : co_up;
    end
endmodule

// File: rtl/acs4_best.sv
module acs4_best
    import acs4_pkg::*;
#(
    parameter int MW = 5
) (
    input  logic [NST-1:0][MW-1:0] pm_i,
    output logic [SW-1:0]          best_o
);
    logic [1:0][MW-1:0] l1_pm;
    logic [1:0]         l1_hi;

    for (genvar g = 0; g < 2; g++) begin : g_l1
        logic [MW-1:0] d;
        always_comb begin
            d        = pm_i[2*g+1] - pm_i[2*g];
            l1_hi[g] = d[MW-1];
            l1_pm[g] = l1_hi[g] ? pm_i[2*g+1] : pm_i[2*g];
        end
    end

    logic [MW-1:0] d2;
    logic          pick1;
    always_comb begin
        d2     = l1_pm[1] - l1_pm[0];
        pick1  = d2[MW-1];
        best_o = pick1 ? {1'b1, l1_hi[1]} : {1'b0, l1_hi[0]};
    end
endmodule

// File: rtl/acs4_hd.sv
module acs4_hd
    import acs4_pkg::*;
#(
    parameter int MW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              in_valid_i,
    input  logic [1:0]        sym_i,
    output logic [NST*MW-1:0] metric_o,
    output logic [NST-1:0]    dec_o,
    output logic [SW-1:0]     best_o,
    output logic              out_valid_o
);
    typedef struct packed {
        logic [NST-1:0][MW-1:0] pm;
        logic [NST-1:0]         dec;
        logic [SW-1:0]          best;
        logic                   vld;
    } st_t;

    st_t st_d, st_q;

    logic [NLAB-1:0][BMW-1:0] bm;
    logic [NST-1:0][MW-1:0]   pm_new;
    logic [NST-1:0]           dec_new;
    logic [SW-1:0]            best_new;

    acs4_bmu u_bmu (.sym_i(sym_i), .bm_o(bm));

    for (genvar j = 0; j < NBF; j++) begin : g_bf
        acs4_bfly #(.MW(MW), .J(j)) u_bf (
            .pm_up_i   (st_q.pm[j]),
            .pm_lo_i   (st_q.pm[j+NBF]),
            .bm_i      (bm),
            .pm_even_o (pm_new[2*j]),
            .pm_odd_o  (pm_new[2*j+1]),
            .dec_even_o(dec_new[2*j]),
            .dec_odd_o (dec_new[2*j+1])
        );
    end

    acs4_best #(.MW(MW)) u_best (.pm_i(pm_new), .best_o(best_new));

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clr_i) begin
            st_d = '0;
        end else if (in_valid_i) begin
            st_d.pm   = pm_new;
            st_d.dec  = dec_new;
            st_d.best = best_new;
            st_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign metric_o    = st_q.pm;
    assign dec_o       = st_q.dec;
    assign best_o      = st_q.best;
    assign out_valid_o = st_q.vld;

    logic [MW-1:0] best_pm;
    logic          spread_ok;
    always_comb begin
        best_pm   = st_q.pm[st_q.best];
        spread_ok = 1'b1;
        for (int s = 0; s < NST; s++) begin
            if (MW'(st_q.pm[s] - best_pm) > MW'(4)) spread_ok = 1'b0;
        end
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (st_q.pm == '0 && st_q.dec == '0 && st_q.best == '0 && !st_q.vld)); // R1
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && !clr_i) |=> out_valid_o); // R7
    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> !out_valid_o); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!in_valid_i && !clr_i) |=> ($stable(metric_o) && $stable(dec_o) && $stable(best_o))); // R7
    AST_MIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && !clr_i) |=> (MW'(best_pm - $past(best_pm)) <= MW'(2))); // R6
    AST_SPREAD: assert property (@(posedge clk) disable iff (rst)
        spread_ok); // R8
endmodule

// File: tb/sim_acs4_hd.sv
`timescale 1ns/1ps
module sim_acs4_hd;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [1:0]  sym_i = 2'b00;
    logic [19:0] metric_o;
    logic [3:0]  dec_o;
    logic [1:0]  best_o;
    logic        out_valid_o;

    int errors = 0;
    int checks = 0;
    int pm [4];
    logic [3:0] exp_dec;
    logic [1:0] exp_best;

    always #2 clk = ~clk;

    acs4_hd u0 (
        .clk(clk), .rst(rst), .clr_i(clr_i), .in_valid_i(in_valid_i), .sym_i(sym_i),
        .metric_o(metric_o), .dec_o(dec_o), .best_o(best_o), .out_valid_o(out_valid_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 4; s++) pm[s] = 0;
        exp_dec = '0;
        exp_best = '0;
    endtask

    // trellis reference: state k, k[0] newest input, next state {k[0],u}
    task automatic model_step(input logic [1:0] r);
        int np [4];
        int bestv;
        for (int s = 0; s < 4; s++) begin
            int cand [2];
            int u;
            u = s & 1;
            for (int w = 0; w < 2; w++) begin
                int p, k0, k1, v0, v1;
                p  = (s >> 1) + 2 * w;
                k0 = p & 1;
                k1 = (p >> 1) & 1;
                v0 = u ^ k0 ^ k1;
                v1 = u ^ k1;
                cand[w] = pm[p] + (v0 ^ int'(r[1])) + (v1 ^ int'(r[0]));
            end
            exp_dec[s] = (cand[1] < cand[0]);
            np[s] = exp_dec[s] ? cand[1] : cand[0];
        end
        bestv = np[0];
        exp_best = 2'd0;
        for (int s = 0; s < 4; s++) begin
            pm[s] = np[s];
            if (np[s] < bestv) begin
                bestv = np[s];
                exp_best = 2'(s);
            end
        end
    endtask

    task automatic check_all(input string tag, input int vld);
        for (int s = 0; s < 4; s++)
            chk({tag, " metric"}, int'(metric_o[s*5 +: 5]), pm[s] % 32);
        chk({tag, " dec"}, int'(dec_o), int'(exp_dec));
        chk({tag, " best"}, int'(best_o), int'(exp_best));
        chk({tag, " vld"}, int'(out_valid_o), vld);
    endtask

    task automatic send(input logic [1:0] r);
        @(negedge clk);
        in_valid_i = 1'b1;
        sym_i = r;
        @(posedge clk);
        @(negedge clk);
        in_valid_i = 1'b0;
        model_step(r);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_i = 1'b0;
        model_clear();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        check_all("R1 reset", 0);
    endtask

    task automatic t_single();
        for (int v = 0; v < 4; v++) begin
            do_clear();
            send(2'(v));
            check_all("R2 R3 R4 single symbol", 1);
        end
    endtask

    task automatic t_example();
        logic [1:0] rx [6];
        rx = '{2'b10, 2'b01, 2'b01, 2'b00, 2'b10, 2'b11};
        do_clear();
        for (int i = 0; i < 6; i++) begin
            send(rx[i]);
            check_all("R4 R6 example step", 1);
        end
        chk("R9 state0 metric", int'(metric_o[4:0]), 1);
        chk("R9 best state", int'(best_o), 0);
    endtask

    task automatic t_zero_stream();
        do_clear();
        for (int i = 0; i < 10; i++) begin
            send(2'b00);
            check_all("R4 zero stream", 1);
        end
        chk("R6 zero stream best", int'(best_o), 0);
    endtask

    task automatic t_idle();
        logic [19:0] m0;
        m0 = metric_o;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_all("R7 idle hold", 0);
            chk("R7 idle metric bus", int'(metric_o == m0), 1);
        end
    endtask

    task automatic t_long();
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        do_clear();
        for (int i = 0; i < 400; i++) begin
            logic [1:0] r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r = lfsr[1:0];
            if (i % 3 == 0) r = r ^ 2'b11;
            send(r);
            check_all("R5 R6 R8 long wrap", 1);
        end
        chk("R5 metrics wrapped", int'(pm[0] > 64), 1);
    endtask

    task automatic t_clear_mid();
        send(2'b11);
        send(2'b01);
        @(negedge clk);
        clr_i = 1'b1;
        in_valid_i = 1'b1;
        sym_i = 2'b10;
        @(posedge clk);
        @(negedge clk);
        clr_i = 1'b0;
        in_valid_i = 1'b0;
        model_clear();
        check_all("R1 clear over valid", 0);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_example();
        t_idle();
        t_zero_stream();
        t_long();
        t_idle();
        t_clear_mid();
        t_example();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule